// File: doc/BRIEF.md
# Indirect Interrupt-Routing Register Window

This block is the software-visible face of an interrupt router. Software sees only two registers on the bus: a select register and a data window. A write at the select offset stores an 8-bit index. Reads and writes at the window offset then reach the register that index names. That register is the router identifier, a read-only version word, or one 32-bit half of the 64-bit routing entry that belongs to each input pin.

The block holds the routing table storage and the identifier field. The whole table is exported in flat form to the pin logic. The pin logic reports two things back: which pins hold a pending request, and when a level-triggered delivery has set a pin's remote-IRR bit. Two one-cycle strobes go the other way. One reports a change of an entry's mask bit. The other asks the pin logic to retry delivery on a pin, after software has rewritten that pin's entry while a level request is pending.

Top module: `irq_route_window`

## Requirements
- R1: A write at the select offset (`SEL_OFF`) keeps only bits 7:0 of the write data as the index. A read at the select offset returns that index in bits 7:0, with zeros above.
- R2: Index 0x01 reads `NPINS-1` in bits 23:16 and `VERSION` in bits 7:0, with every other bit zero. Writes to index 0x01 change nothing.
- R3: Index 0x00 holds a 4-bit identifier in bits 27:24 and is writable. Index 0x02 reads back the same identifier in the same bits. Writes to index 0x02 change nothing.
- R4: An index of 0x10 or more selects entry number (index − 0x10) >> 1. An even index reaches bits 31:0 of that entry and an odd index reaches bits 63:32.
- R5: Reading an entry number at or beyond `NPINS`, or any index from 0x03 to 0x0F, returns 0xFFFFFFFF. Writes to such an index are dropped.
- R6: Entry bit 14 is the remote-IRR bit. A pulse on `rirr_set[i]` sets it in entry i. A write to an entry's low half stores 0 in bit 14, whatever the data holds. A write to the high half leaves bit 14 as it was.
- R7: After reset, every entry reads 0x0000_0000_0001_0000 (mask bit 16 set, all else clear), and the select register and the identifier are zero. No strobe is active.
- R8: When a window write changes an entry's mask bit (bit 16), `mask_evt_valid` is high for exactly the next cycle, with the pin number and the new mask value. A write that leaves the mask unchanged raises no event.
- R9: After a window write to an in-range entry whose trigger-mode bit 15 is 1 (level) once the write has landed, and whose `pin_pending` bit is set, `retry_valid` is high for the next cycle with that pin number. An edge-mode entry, or a pin with no pending request, gives no strobe.
- R10: Bus reads at any offset other than the select and window offsets return zero, and writes there change no state. `bus_rdata` is zero when `bus_rd` is low.
- R11: `route_table` presents entry i in bits 64*i+63 : 64*i, with the same value the window reads back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe; read data is combinational |
| bus_addr | input | 8 | Byte offset inside the aperture |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| pin_pending | input | NPINS | Pending-request bit per pin, from the pin logic |
| rirr_set | input | NPINS | Pulse that sets an entry's remote-IRR bit |
| route_table | output | 64*NPINS | All routing entries, flattened |
| mask_evt_valid | output | 1 | One-cycle mask-change event |
| mask_evt_pin | output | PIN_W | Pin whose mask changed |
| mask_evt_value | output | 1 | New mask value |
| retry_valid | output | 1 | One-cycle retry-delivery strobe |
| retry_pin | output | PIN_W | Pin to retry |

## Verification
The bench builds the block with `NPINS` = 4 and `VERSION` = 0x20. With only four pins, an entry number past the end of the table is a single index away (0x18). That makes the all-ones read and the dropped write easy to reach, and the version word shows a small, recognisable pin-count field. Four entries are also enough to check that writes to one entry leave its neighbours alone. They also let mask events, retry strobes and remote-IRR updates be aimed at different pins in turn.

// File: rtl/irq_route_pkg.sv
// Package irq_route_pkg
// Shared index-kind encoding and routing-entry bit positions for the
// indirect register window. Assumes a 64-bit entry and an 8-bit index.
package irq_route_pkg;

    localparam int IDX_W    = 8;
    localparam int DATA_W   = 32;
    localparam int ENTRY_W  = 64;

    // Entry bit positions that this block itself interprets
    localparam int BIT_RIRR = 14;
    localparam int BIT_TRIG = 15;
    localparam int BIT_MASK = 16;

    // Reset value of every entry: masked, everything else clear
    localparam logic [ENTRY_W-1:0] ENTRY_RST = 64'h0000_0000_0001_0000;

    // Indices with a fixed meaning
    localparam logic [IDX_W-1:0] IDX_IDENT = 8'h00;
    localparam logic [IDX_W-1:0] IDX_VERS  = 8'h01;
    localparam logic [IDX_W-1:0] IDX_ALIAS = 8'h02;
    localparam logic [IDX_W-1:0] IDX_TBASE = 8'h10;

    typedef enum logic [2:0] {
        KIND_IDENT,
        KIND_VERS,
        KIND_ALIAS,
        KIND_ENTRY,
        KIND_NONE
    } idx_kind_e;

endpackage

// File: rtl/irq_route_decode.sv
// Module irq_route_decode
// Turns the 8-bit select index into a register kind, an entry number and
// a half selector. Pure combinational logic. Assumes NPINS <= 120, so that
// every pin has an index below 0x100.
module irq_route_decode
    import irq_route_pkg::*;
#(
    parameter int NPINS = 24,
    localparam int PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic [IDX_W-1:0] sel,
    output idx_kind_e        kind,
    output logic             in_range,
    output logic [PIN_W-1:0] pin,
    output logic             hi_half
);
    logic [IDX_W-1:0] offs;
    logic [IDX_W-2:0] ent_num;

    // Entry number and half from the index above the table base
    always_comb begin
        offs    = sel - IDX_TBASE;
        ent_num = offs[IDX_W-1:1];
        hi_half = sel[0];
        pin     = ent_num[PIN_W-1:0];
    end

    // Classify the index
    always_comb begin
        in_range = 1'b0;
        if (sel == IDX_IDENT)      kind = KIND_IDENT;
        else if (sel == IDX_VERS)  kind = KIND_VERS;
        else if (sel == IDX_ALIAS) kind = KIND_ALIAS;
        else if (sel >= IDX_TBASE) begin
            kind     = KIND_ENTRY;
            in_range = (32'(ent_num) < 32'(NPINS));
        end
        else                       kind = KIND_NONE;
    end
endmodule

// File: rtl/irq_route_bank.sv
// Module irq_route_bank
// Holds the routing entries, one 64-bit register per pin. A low-half write
// stores the data with the remote-IRR bit forced to zero. A high-half write
// replaces bits 63:32. The pin logic may set remote-IRR with a pulse; a
// low-half write in the same cycle wins.
module irq_route_bank
    import irq_route_pkg::*;
#(
    parameter int NPINS = 24
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NPINS-1:0]         lo_we,
    input  logic [NPINS-1:0]         hi_we,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [NPINS-1:0]         rirr_set,
    output logic [NPINS*ENTRY_W-1:0] table_flat
);
    genvar gi;
    generate
        for (gi = 0; gi < NPINS; gi++) begin : g_ent
            logic [ENTRY_W-1:0] ent;

            // Update one entry from the window or the pin logic
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ent <= ENTRY_RST;
                end else begin
                    if (lo_we[gi]) begin
                        ent[DATA_W-1:0]  <= wdata;
                        ent[BIT_RIRR]    <= 1'b0;
                    end else if (rirr_set[gi]) begin
                        ent[BIT_RIRR]    <= 1'b1;
                    end
                    if (hi_we[gi]) begin
                        ent[ENTRY_W-1:DATA_W] <= wdata;
                    end
                end
            end

            assign table_flat[gi*ENTRY_W +: ENTRY_W] = ent;

            // R6: a low-half write leaves remote-IRR clear
            assert_lo_clears_rirr_R6: assert property (@(posedge clk) disable iff (!rst_n)
                lo_we[gi] |=> !ent[BIT_RIRR]);

            // R6: a high-half write alone keeps remote-IRR
            assert_hi_keeps_rirr_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (hi_we[gi] && !rirr_set[gi]) |=> (ent[BIT_RIRR] == $past(ent[BIT_RIRR])));
        end
    endgenerate
endmodule

// File: rtl/irq_route_events.sv
// Module irq_route_events
// Builds the registered one-cycle strobes that follow a window write to an
// in-range entry: a mask-change event and a retry-delivery request. Works
// from the entry value before the write and the value the write produces.
module irq_route_events
    import irq_route_pkg::*;
#(
    parameter int NPINS = 24,
    localparam int PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ent_wr,
    input  logic               hi_half,
    input  logic [PIN_W-1:0]   pin,
    input  logic [ENTRY_W-1:0] old_ent,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [NPINS-1:0]   pin_pending,
    output logic               mask_evt_valid,
    output logic [PIN_W-1:0]   mask_evt_pin,
    output logic               mask_evt_value,
    output logic               retry_valid,
    output logic [PIN_W-1:0]   retry_pin
);
    logic new_mask;
    logic new_trig;
    logic pend;

    // Mask and trigger bits as they stand once the write lands
    always_comb begin
        new_mask = hi_half ? old_ent[BIT_MASK] : wdata[BIT_MASK];
        new_trig = hi_half ? old_ent[BIT_TRIG] : wdata[BIT_TRIG];
        pend     = pin_pending[pin];
    end

    // Register the mask-change event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_evt_valid <= 1'b0;
            mask_evt_pin   <= '0;
            mask_evt_value <= 1'b0;
        end else begin
            mask_evt_valid <= ent_wr && (new_mask != old_ent[BIT_MASK]);
            mask_evt_pin   <= pin;
            mask_evt_value <= new_mask;
        end
    end

    // Register the retry strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            retry_valid <= 1'b0;
            retry_pin   <= '0;
        end else begin
            retry_valid <= ent_wr && new_trig && pend;
            retry_pin   <= pin;
        end
    end

    // R8: an event only ever follows an entry write
    assert_evt_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mask_evt_valid |-> $past(ent_wr));

    // R9: a retry only follows an entry write on a pending pin
    assert_retry_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        retry_valid |-> ($past(ent_wr) && $past(pend)));
endmodule

// File: rtl/irq_route_window.sv
// Module irq_route_window
// Top level of the indirect routing-register window. Decodes the two bus
// offsets, holds the select index and the identifier, and routes window
// accesses to the version word, the identifier or the entry bank.
// Assumes single-cycle bus strobes and at most one of bus_rd and bus_wr.
module irq_route_window
    import irq_route_pkg::*;
#(
    parameter int NPINS        = 24,
    parameter logic [7:0] VERSION = 8'h11,
    parameter logic [7:0] SEL_OFF = 8'h00,
    parameter logic [7:0] WIN_OFF = 8'h10,
    localparam int PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    input  logic [7:0]               bus_addr,
    input  logic [31:0]              bus_wdata,
    output logic [31:0]              bus_rdata,
    input  logic [NPINS-1:0]         pin_pending,
    input  logic [NPINS-1:0]         rirr_set,
    output logic [NPINS*64-1:0]      route_table,
    output logic                     mask_evt_valid,
    output logic [PIN_W-1:0]         mask_evt_pin,
    output logic                     mask_evt_value,
    output logic                     retry_valid,
    output logic [PIN_W-1:0]         retry_pin
);
    localparam logic [7:0] MAX_PIN = 8'(NPINS - 1);

    logic [IDX_W-1:0]   sel_q;
    logic [3:0]         ident_q;
    idx_kind_e          kind;
    logic               in_range;
    logic [PIN_W-1:0]   pin;
    logic               hi_half;
    logic               sel_wr, win_wr, ent_wr;
    logic [NPINS-1:0]   lo_we, hi_we;
    logic [ENTRY_W-1:0] cur_ent;
    logic [DATA_W-1:0]  win_rdata;

    irq_route_decode #(.NPINS(NPINS)) u_dec (
        .sel      (sel_q),
        .kind     (kind),
        .in_range (in_range),
        .pin      (pin),
        .hi_half  (hi_half)
    );

    // Qualify bus writes by offset
    always_comb begin
        sel_wr = bus_wr && (bus_addr == SEL_OFF);
        win_wr = bus_wr && (bus_addr == WIN_OFF);
        ent_wr = win_wr && (kind == KIND_ENTRY) && in_range;
    end

    // One write enable per entry half
    always_comb begin
        lo_we = '0;
        hi_we = '0;
        if (ent_wr) begin
            lo_we[pin] = !hi_half;
            hi_we[pin] = hi_half;
        end
    end

    // Select register and identifier
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= '0;
            ident_q <= '0;
        end else begin
            if (sel_wr) sel_q <= bus_wdata[IDX_W-1:0];
            if (win_wr && kind == KIND_IDENT) ident_q <= bus_wdata[27:24];
        end
    end

    irq_route_bank #(.NPINS(NPINS)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .lo_we      (lo_we),
        .hi_we      (hi_we),
        .wdata      (bus_wdata),
        .rirr_set   (rirr_set),
        .table_flat (route_table)
    );

    // Entry addressed by the current index
    always_comb begin
        cur_ent = ENTRY_RST;
        for (int i = 0; i < NPINS; i++) begin
            if (32'(pin) == i) cur_ent = route_table[i*ENTRY_W +: ENTRY_W];
        end
    end

    irq_route_events #(.NPINS(NPINS)) u_evt (
        .clk            (clk),
        .rst_n          (rst_n),
        .ent_wr         (ent_wr),
        .hi_half        (hi_half),
        .pin            (pin),
        .old_ent        (cur_ent),
        .wdata          (bus_wdata),
        .pin_pending    (pin_pending),
        .mask_evt_valid (mask_evt_valid),
        .mask_evt_pin   (mask_evt_pin),
        .mask_evt_value (mask_evt_value),
        .retry_valid    (retry_valid),
        .retry_pin      (retry_pin)
    );

    // Window read value for the current index
    always_comb begin
        unique case (kind)
            KIND_IDENT, KIND_ALIAS: win_rdata = {4'h0, ident_q, 24'h0};
            KIND_VERS:              win_rdata = {8'h0, MAX_PIN, 8'h0, VERSION};
            KIND_ENTRY:             win_rdata = in_range ?
                                        (hi_half ? cur_ent[63:32] : cur_ent[31:0]) : '1;
            default:                win_rdata = '1;
        endcase
    end

    // Bus read mux over the two offsets
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (bus_addr == SEL_OFF)      bus_rdata = {24'h0, sel_q};
            else if (bus_addr == WIN_OFF) bus_rdata = win_rdata;
        end
    end

    // R1: the select register takes the low byte of a select write
    assert_sel_low_byte_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sel_wr |=> (sel_q == $past(bus_wdata[7:0])));

    // R3: only a window write at index 0x00 moves the identifier
    assert_ident_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(win_wr && kind == KIND_IDENT) |=> $stable(ident_q));

    // R10: a write at a foreign offset leaves the select register alone
    assert_foreign_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr != SEL_OFF) |=> $stable(sel_q));
endmodule

// File: tb/tb_irq_route_window.sv
module tb_irq_route_window;
    localparam int NP = 4;
    localparam int PW = 2;
    localparam logic [7:0] SEL = 8'h00;
    localparam logic [7:0] WIN = 8'h10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NP-1:0] pin_pending = '0, rirr_set = '0;
    logic [NP*64-1:0] route_table;
    logic mask_evt_valid, mask_evt_value, retry_valid;
    logic [PW-1:0] mask_evt_pin, retry_pin;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    irq_route_window #(.NPINS(NP), .VERSION(8'h20)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_pending(pin_pending), .rirr_set(rirr_set), .route_table(route_table),
        .mask_evt_valid(mask_evt_valid), .mask_evt_pin(mask_evt_pin),
        .mask_evt_value(mask_evt_value), .retry_valid(retry_valid),
        .retry_pin(retry_pin)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  idx;
        logic [31:0] data;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'h10, 32'h0000_8031, 32'h0, 8'd4},           // R4 entry0 low, level, unmasked
        '{1'b0, 8'h10, 32'h0, 32'h0000_8031, 8'd4},           // R4
        '{1'b1, 8'h11, 32'hAB00_0000, 32'h0, 8'd4},           // R4 entry0 high
        '{1'b0, 8'h11, 32'h0, 32'hAB00_0000, 8'd4},           // R4
        '{1'b0, 8'h12, 32'h0, 32'h0001_0000, 8'd7},           // R7 entry1 still reset
        '{1'b1, 8'h17, 32'h1234_5678, 32'h0, 8'd4},           // R4 entry3 high
        '{1'b0, 8'h17, 32'h0, 32'h1234_5678, 8'd4},           // R4
        '{1'b0, 8'h16, 32'h0, 32'h0001_0000, 8'd4},           // R4 low half untouched
        '{1'b0, 8'h18, 32'h0, 32'hFFFF_FFFF, 8'd5},           // R5 entry4 absent
        '{1'b1, 8'h18, 32'h0, 32'h0, 8'd5},                   // R5 dropped write
        '{1'b0, 8'h05, 32'h0, 32'hFFFF_FFFF, 8'd5},           // R5 gap index
        '{1'b0, 8'h01, 32'h0, 32'h0003_0020, 8'd2},           // R2 version word
        '{1'b1, 8'h01, 32'hFFFF_FFFF, 32'h0, 8'd2},           // R2 write discarded
        '{1'b0, 8'h01, 32'h0, 32'h0003_0020, 8'd2},           // R2
        '{1'b1, 8'h00, 32'hFA00_0000, 32'h0, 8'd3},           // R3 identifier write
        '{1'b0, 8'h02, 32'h0, 32'h0A00_0000, 8'd3},           // R3 alias read
        '{1'b1, 8'h14, 32'h0000_4042, 32'h0, 8'd6}            // R6 data bit14 not stored
    };

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bwrite(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bread(input logic [7:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #2 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic win_wr(input logic [7:0] idx, input logic [31:0] d);
        bwrite(SEL, {24'h0, idx});
        bwrite(WIN, d);
    endtask

    task automatic win_rd(input logic [7:0] idx, output logic [31:0] d);
        bwrite(SEL, {24'h0, idx});
        bread(WIN, d);
    endtask

    // Watchdog: a hung run is a failed check
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R7: reset state
        bread(SEL, r);                      chk(r, 32'h0, "R7 select");
        chk({31'h0, mask_evt_valid | retry_valid}, 32'h0, "R7 strobes");
        win_rd(8'h00, r);                   chk(r, 32'h0, "R7 ident");
        for (int p = 0; p < NP; p++) begin
            win_rd(8'(8'h10 + 2*p), r);     chk(r, 32'h0001_0000, "R7 entry low");
            win_rd(8'(8'h11 + 2*p), r);     chk(r, 32'h0, "R7 entry high");
        end

        // Vector table walk
        for (int v = 0; v < NV; v++) begin
            if (VECS[v].wr) begin
                win_wr(VECS[v].idx, VECS[v].data);
            end else begin
                win_rd(VECS[v].idx, r);
                chk(r, VECS[v].exp, $sformatf("R%0d vector %0d", VECS[v].req, v));
            end
        end
        win_rd(8'h14, r);                   chk(r, 32'h0000_0042, "R6 low write bit14");
        win_rd(8'h00, r);                   chk(r, 32'h0A00_0000, "R3 ident");
        win_wr(8'h02, 32'h0500_0000);
        win_rd(8'h00, r);                   chk(r, 32'h0A00_0000, "R3 alias write ignored");

        // R1: only the low byte lands in the select register
        bwrite(SEL, 32'hABCD_12F5);
        bread(SEL, r);                      chk(r, 32'h0000_00F5, "R1 select byte");

        // R10: foreign offsets
        bwrite(8'h20, 32'h0000_0011);
        bread(SEL, r);                      chk(r, 32'h0000_00F5, "R10 select untouched");
        bread(8'h20, r);                    chk(r, 32'h0, "R10 foreign read");
        chk(bus_rdata, 32'h0, "R10 idle rdata");

        // R8: mask-change events on entry2 (index 0x14, mask currently 0)
        win_wr(8'h14, 32'h0001_0000);
        chk({31'h0, mask_evt_valid}, 32'h1, "R8 event raised");
        chk({30'h0, mask_evt_pin}, 32'h2, "R8 event pin");
        chk({31'h0, mask_evt_value}, 32'h1, "R8 event value");
        @(negedge clk);
        chk({31'h0, mask_evt_valid}, 32'h0, "R8 one cycle");
        win_wr(8'h14, 32'h0001_0055);
        chk({31'h0, mask_evt_valid}, 32'h0, "R8 no change no event");
        win_wr(8'h15, 32'hFFFF_FFFF);
        chk({31'h0, mask_evt_valid}, 32'h0, "R8 high half no event");
        win_wr(8'h14, 32'h0000_0000);
        chk({31'h0, mask_evt_value}, 32'h0, "R8 unmask value");
        chk({31'h0, mask_evt_valid}, 32'h1, "R8 unmask event");

        // R9: retry strobes on entry1 (index 0x12)
        pin_pending = 4'b0010;
        win_wr(8'h12, 32'h0001_8000);
        chk({31'h0, retry_valid}, 32'h1, "R9 level pending retry");
        chk({30'h0, retry_pin}, 32'h1, "R9 retry pin");
        win_wr(8'h12, 32'h0001_0000);
        chk({31'h0, retry_valid}, 32'h0, "R9 edge no retry");
        pin_pending = 4'b0000;
        win_wr(8'h12, 32'h0001_8000);
        chk({31'h0, retry_valid}, 32'h0, "R9 no pending no retry");

        // R6: remote-IRR set, kept by high write, cleared by low write (entry0)
        @(negedge clk); rirr_set = 4'b0001;
        @(negedge clk); rirr_set = 4'b0000;
        win_rd(8'h10, r);                   chk(r, 32'h0000_C031, "R6 rirr set");
        win_wr(8'h11, 32'h5500_0000);
        win_rd(8'h10, r);                   chk(r, 32'h0000_C031, "R6 high write keeps");
        win_wr(8'h10, 32'h0000_8031);
        win_rd(8'h10, r);                   chk(r, 32'h0000_8031, "R6 low write clears");

        // R11: flattened table matches window
        chk(route_table[31:0], 32'h0000_8031, "R11 entry0 low");
        chk(route_table[63:32], 32'h5500_0000, "R11 entry0 high");
        chk(route_table[255:224], 32'h1234_5678, "R11 entry3 high");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule